// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block translates 32-bit virtual addresses into 24-bit physical addresses for a machine with 1 KB pages. It holds a small set of translations. On every lookup, all entries are compared against the virtual page number at once, each with its own comparator. On a hit, the block returns the stored 14-bit frame number joined with the untouched 10-bit page offset, and it does so in the same cycle. On a miss, it raises a miss flag and produces no address. Software then walks its page table, loads the missing translation through the write port, and retries the access, which now hits.

Each entry carries a valid bit and a dirty bit. A store that hits marks its entry dirty. A flush pulse, issued when a new user process starts, invalidates every entry. The block always shows which entry the next load would replace: the lowest-numbered empty entry if one exists, and otherwise the least recently used one. Along with that index it shows the entry's valid bit, dirty bit and page number. Refill software uses these to write a dirty translation back to the page table before overwriting it.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, and the reported victim is entry 0 with `vic_valid` low.
- R2: When `lk_vld` is high and a valid entry holds the page number `lk_va[31:10]`, `lk_hit` is high in the same cycle and `lk_pa` equals that entry's frame in bits [23:10] and `lk_va[9:0]` in bits [9:0].
- R3: When a lookup finds no valid matching entry, `lk_miss` is high, `lk_hit` is low and `lk_pa` is zero. When `lk_vld` is low, both `lk_hit` and `lk_miss` are low.
- R4: A load (`wr_en` high, `flush` low) writes `wr_vpn` and `wr_pfn` into the target entry, sets its valid bit and clears its dirty bit. From the next cycle on, a lookup of that page hits with the new frame.
- R5: `flush` clears every valid bit on the next edge. A load presented in the same cycle as a flush is discarded, so a lookup of its page misses afterwards.
- R6: A lookup with `lk_store` high that hits sets the dirty bit of the matching entry. The bit is visible on `vic_dirty` once that entry becomes the victim.
- R7: A lookup hit or a load makes the touched entry the most recently used. The victim is the lowest-indexed invalid entry if any entry is invalid, and otherwise the least recently used entry.
- R8: `vic_idx`, `vic_valid`, `vic_dirty` and `vic_vpn` describe, combinationally, the entry that a load in the current cycle would replace.
- R9: A load whose page number is already held by a valid entry overwrites that entry in place, not the victim. Afterwards the page returns only the new frame, and its dirty bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is a store; marks the hit entry dirty |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; software refill needed |
| lk_pa | output | 24 | Translated physical address, zero unless hit |
| flush | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Load one translation |
| wr_vpn | input | 22 | Virtual page number to load |
| wr_pfn | input | 14 | Physical frame number to load |
| vic_idx | output | 6 | Entry the next load replaces |
| vic_valid | output | 1 | Victim entry holds a translation |
| vic_dirty | output | 1 | Victim entry was written through |
| vic_vpn | output | 22 | Page number held by the victim entry |

## Verification
The bench builds the buffer with 8 entries instead of 64, which narrows `vic_idx` to 3 bits. With only eight entries, random lookups over a pool of twelve pages overflow the buffer constantly. Full-buffer least-recently-used eviction, dirty write-back reporting and the return to empty-slot victims after a flush therefore all occur thousands of times within the run. Address widths stay at their default values, so offset concatenation and the extreme page numbers 0 and 0x3FFFFF are exercised at full width.

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int OFF_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_vld,
  input  logic [VA_W-1:0]               lk_va,
  input  logic                          lk_store,
  output logic                          lk_hit,
  output logic                          lk_miss,
  output logic [PA_W-1:0]               lk_pa,
  input  logic                          flush,
  input  logic                          wr_en,
  input  logic [VA_W-OFF_W-1:0]         wr_vpn,
  input  logic [PA_W-OFF_W-1:0]         wr_pfn,
  output logic [$clog2(ENTRIES)-1:0]    vic_idx,
  output logic                          vic_valid,
  output logic                          vic_dirty,
  output logic [VA_W-OFF_W-1:0]         vic_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IW    = $clog2(ENTRIES);
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [IW-1:0]    age_q [ENTRIES];
  logic [ENTRIES-1:0] val_q, dty_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_match, wr_match;
  logic [IW-1:0]      hit_idx, same_idx, free_idx, lru_idx, tgt_idx, touch_idx;
  logic               hit_any, same_any, free_any, touch_en;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = val_q[g] && (vpn_q[g] == lk_vpn);
    assign wr_match[g] = val_q[g] && (vpn_q[g] == wr_vpn);
  end

  always_comb begin
    hit_idx  = '0; hit_any  = 1'b0;
    same_idx = '0; same_any = 1'b0;
    free_idx = '0; free_any = 1'b0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin hit_idx  = IW'(i); hit_any  = 1'b1; end
      if (wr_match[i]) begin same_idx = IW'(i); same_any = 1'b1; end
      if (!val_q[i])   begin free_idx = IW'(i); free_any = 1'b1; end
      if (age_q[i] == OLDEST) lru_idx = IW'(i);
    end
  end

  assign vic_idx   = free_any ? free_idx : lru_idx;
  assign vic_valid = val_q[vic_idx];
  assign vic_dirty = dty_q[vic_idx];
  assign vic_vpn   = vpn_q[vic_idx];
  assign tgt_idx   = same_any ? same_idx : vic_idx;

  assign lk_hit  = lk_vld && hit_any;
  assign lk_miss = lk_vld && !hit_any;
  assign lk_pa   = lk_hit ? {pfn_q[hit_idx], lk_va[OFF_W-1:0]} : '0;

  assign touch_en  = !flush && (wr_en || lk_hit);
  assign touch_idx = wr_en ? tgt_idx : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
    end else begin
      if (flush) begin
        val_q <= '0;
      end else if (wr_en) begin
        val_q[tgt_idx] <= 1'b1;
        dty_q[tgt_idx] <= 1'b0;
      end else if (lk_hit && lk_store) begin
        dty_q[hit_idx] <= 1'b1;
      end
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IW'(i) == touch_idx)             age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[tgt_idx] <= wr_vpn;
      pfn_q[tgt_idx] <= wr_pfn;
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int VPN_W = 22,
  parameter int PFN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_vld,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [PFN_W-1:0] lk_frame,
  input logic             flush,
  input logic             wr_en,
  input logic [VPN_W-1:0] wr_vpn,
  input logic [PFN_W-1:0] wr_pfn,
  input logic             vic_valid,
  input logic [VPN_W-1:0] vic_vpn
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |-> !lk_hit && !lk_miss); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !vic_valid); // R5

  AST_LOAD_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> !(lk_vld && lk_vpn == $past(wr_vpn)) ||
                          (lk_hit && lk_frame == $past(wr_pfn))); // R4

  AST_LOAD_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> !(vic_valid && vic_vpn == $past(wr_vpn))); // R7

  AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !wr_en && !flush) |=> !(vic_valid && vic_vpn == $past(lk_vpn))); // R7
endmodule

bind xlat_buf xlat_buf_chk #(.VPN_W(VA_W - OFF_W), .PFN_W(PA_W - OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_vpn(lk_va[VA_W-1:OFF_W]),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_frame(lk_pa[PA_W-1:OFF_W]),
  .flush(flush), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn),
  .vic_valid(vic_valid), .vic_vpn(vic_vpn));

// File: tb/xlat_buf_test.sv
module xlat_buf_test;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_vld = 0, lk_store = 0, flush = 0, wr_en = 0;
  logic [31:0] lk_va = '0;
  logic [21:0] wr_vpn = '0;
  logic [13:0] wr_pfn = '0;
  logic lk_hit, lk_miss, vic_valid, vic_dirty;
  logic [23:0] lk_pa;
  logic [IW-1:0] vic_idx;
  logic [21:0] vic_vpn;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [21:0] m_vpn [N];
  logic [13:0] m_pfn [N];
  bit m_val [N];
  bit m_dty [N];
  int m_ord [N];

  always #2 clk = ~clk;

  xlat_buf #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_va(lk_va), .lk_store(lk_store),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .flush(flush),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .vic_idx(vic_idx),
    .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_vpn(vic_vpn));

  task automatic chk(input string tg, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [21:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return m_ord[N-1];
  endfunction

  task automatic m_touch(input int k);
    int p = 0;
    for (int i = 0; i < N; i++) if (m_ord[i] == k) p = i;
    for (int j = p; j > 0; j--) m_ord[j] = m_ord[j-1];
    m_ord[0] = k;
  endtask

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_dty[i] = 0; m_ord[i] = i; m_vpn[i] = '0; m_pfn[i] = '0;
    end
  endtask

  task automatic step(input bit vld, input logic [31:0] va, input bit st, input bit fl,
                      input bit we, input logic [21:0] wv, input logic [13:0] wp,
                      input string tg);
    int e, v, t;
    @(negedge clk);
    lk_vld = vld; lk_va = va; lk_store = st; flush = fl; wr_en = we; wr_vpn = wv; wr_pfn = wp;
    #1;
    e = m_find(va[31:10]);
    chk(tg, "lk_hit", lk_hit, vld && e >= 0);
    chk(tg, "lk_miss", lk_miss, vld && e < 0);
    chk(tg, "lk_pa", lk_pa, (vld && e >= 0) ? {m_pfn[e], va[9:0]} : 24'h0);
    v = m_victim();
    chk(tg, "vic_idx", vic_idx, v);
    chk(tg, "vic_valid", vic_valid, m_val[v]);
    if (m_val[v]) begin
      chk(tg, "vic_dirty", vic_dirty, m_dty[v]);
      chk(tg, "vic_vpn", vic_vpn, m_vpn[v]);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
    end else if (we) begin
      t = m_find(wv);
      if (t < 0) t = v;
      m_vpn[t] = wv; m_pfn[t] = wp; m_val[t] = 1; m_dty[t] = 0;
      m_touch(t);
    end else if (vld && e >= 0) begin
      if (st) m_dty[e] = 1;
      m_touch(e);
    end
  endtask

  task automatic look(input logic [21:0] v, input logic [9:0] off, input bit st, input string tg);
    step(1, {v, off}, st, 0, 0, '0, '0, tg);
  endtask

  task automatic load(input logic [21:0] v, input logic [13:0] p, input string tg);
    step(0, '0, 0, 0, 1, v, p, tg);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look(22'h0, 10'h0, 0, "R1");
    look(22'h3FFFFF, 10'h155, 0, "R1");

    load(22'h0, 14'h3FFF, "R4");
    look(22'h0, 10'h3FF, 0, "R2");
    look(22'h0, 10'h000, 0, "R2");
    step(0, {22'h0, 10'h3}, 0, 0, 0, '0, '0, "R3");
    look(22'h3FFFFF, 10'h2A, 0, "R3");

    for (int i = 1; i < N; i++) load(22'(i * 3 + 22'h3FFF00), 14'(i * 17), "R7");
    step(0, '0, 0, 0, 0, '0, '0, "R7");

    look(22'h3FFF09, 10'h10, 1, "R6");
    look(22'h0, 10'h1, 0, "R7");
    for (int i = 1; i < N; i++) if (i != 3) look(22'(i * 3 + 22'h3FFF00), 10'h7, 0, "R7");
    step(0, '0, 0, 0, 0, '0, '0, "R6");
    chk("R6", "vic_dirty_direct", vic_dirty, 1);

    load(22'h3FFF09, 14'h1234, "R9");
    look(22'h3FFF09, 10'h3C, 0, "R9");
    for (int i = 0; i < N; i++) step(0, '0, 0, 0, 0, '0, '0, "R9");

    step(0, '0, 0, 1, 1, 22'h55, 14'h55, "R5");
    look(22'h55, 10'h0, 0, "R5");
    look(22'h0, 10'h0, 0, "R5");
    chk("R5", "vic_valid_after_flush", vic_valid, 0);

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 100;
      logic [21:0] v = 22'h2A000 + 22'($urandom % 12);
      if (op < 3) step(0, '0, 0, 1, 0, '0, '0, "R5");
      else if (op < 25) load(v, 14'($urandom), "R4");
      else begin
        bit absent = (m_find(v) < 0);
        look(v, 10'($urandom), bit'($urandom % 2), "R2");
        if (absent) begin
          load(v, 14'($urandom), "R8");
          look(v, 10'($urandom), 0, "R4");
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule